// File: doc/BRIEF.md
# DMA Channel Command and Interrupt Register Unit

This block is the register-facing control unit of one DMA channel. Software uses a simple register bus to start the channel, to ask it to stop gracefully or to abort it, and to read sticky completion flags. The block turns these commands into level requests for the descriptor fetch engine (`eng_run`, `eng_pause_req`, `eng_abort_req`). It waits for the engine to report `eng_idle` before it declares a stop complete. The engine's descriptor-done, invalid-descriptor and error events are gathered into a 16-bit interrupt status word. Together with a 16-bit enable word, that status word drives a single interrupt line.

The bus has three word addresses. Address 0 holds the control word, which carries commands, configuration, write-one-to-clear completion flags and a busy bit. Address 1 holds the interrupt status word, which is write-one-to-clear. Address 2 holds the interrupt enable word. Reads are combinational from the registers. A graceful stop finishes only once the descriptor already in flight has completed. An abort cuts in at the engine's next burst boundary.

Top module: `dmactl_top`

## Requirements
- R1: After reset the control, interrupt status and interrupt enable words all read 0, `eng_run`, `eng_pause_req`, `eng_abort_req` and `irq` are 0.
- R2: A control write with bit 3 set while the channel is idle starts it. It also loads write-back enable (bit 2), ring-stop (bit 4) and descriptor mode (bits 6:5: 0 block, 1 on-chip, 2 off-chip) from the same word. After the write, bit 30 reads 1 and `eng_run` is 1. The start bit itself reads back 0.
- R3: A control write with bit 0 set while running raises `eng_pause_req`, and bit 0 reads 1 while the stop is pending. Both hold until `eng_idle` is seen. On the edge where it is seen, the channel goes idle and the pause-done flag (bit 9) is set.
- R4: A control write with bit 1 set, while running or pausing, raises `eng_abort_req` and drops any pending pause. Bit 1 reads 1 while the abort is pending. On `eng_idle` the channel goes idle and sets abort-done in the control word (bit 10) and in the interrupt status word (bit 3).
- R5: A pause or abort write to an idle channel sets the matching done flag at once. This holds even when the same write also clears that flag.
- R6: Control bits 8 (invalid descriptor), 9, 10 and 12 (immediate-pause done) are write-one-to-clear. Writing 0 to one of these bits leaves it unchanged.
- R7: When an event and a write-one-to-clear of the same status bit fall in the same cycle, the bit is 1 afterwards.
- R8: Interrupt status bits are set by events: bit 0 by an error, bit 1 by an invalid descriptor, bit 2 by descriptor done and bit 3 by abort done. Each bit is cleared by writing 1 to it.
- R9: Only the enable bits 0, 1, 3, 4 and 5 can be written; all other enable bits read 0.
- R10: `irq` is the OR of status bits 0, 1 and 3 gated by enables 0, 1 and 3, of status bit 2 (always enabled), of pause-done gated by enable 4, and of immediate-pause-done gated by enable 5.
- R11: An invalid-descriptor event while running with ring-stop set stops the channel at once and sets control bits 8 and 12. Without ring-stop the channel keeps running and only bit 8 is set.
- R12: While the channel is busy, writes to the start bit and to the configuration fields have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word address (0 control, 1 status, 2 enable) |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr |
| eng_run | output | 1 | Channel owns the engine |
| eng_pause_req | output | 1 | Graceful stop requested |
| eng_abort_req | output | 1 | Abort requested |
| eng_idle | input | 1 | Engine is at a stop point |
| cfg_wb_en | output | 1 | Descriptor write-back enable |
| cfg_ring_stop | output | 1 | Ring-stop mode |
| cfg_mode | output | 2 | Descriptor mode |
| evt_desc_done | input | 1 | Descriptor completed pulse |
| evt_invalid | input | 1 | Invalid descriptor pulse |
| evt_error | input | 1 | Transfer error pulse |
| irq | output | 1 | Interrupt line |

## Verification
Two functions can collide in one cycle: an engine event setting a sticky bit, and a software write clearing that same bit. The bench provokes this in two ways. In the first, it drives `evt_error` in the same cycle as a write of 1 to status bit 0. In the second, it writes a pause command together with ones in every done position while the channel is idle, so the pause-done set and its own clear coincide. Both cases pass only if the bit reads 1 afterwards. A second overlap is an abort written while a graceful stop is still pending. The bench judges it by checking that the pause request drops and that only abort-done appears.

// File: rtl/dmactl_pkg.sv
package dmactl_pkg;

    typedef enum logic [1:0] {
        CH_IDLE     = 2'd0,
        CH_RUN      = 2'd1,
        CH_PAUSING  = 2'd2,
        CH_ABORTING = 2'd3
    } ch_state_e;

    // control word bit positions
    localparam int C_PAUSE   = 0;
    localparam int C_ABORT   = 1;
    localparam int C_WB      = 2;
    localparam int C_START   = 3;
    localparam int C_RSTOP   = 4;
    localparam int C_MODE_LO = 5;
    localparam int C_INV     = 8;
    localparam int C_PDONE   = 9;
    localparam int C_ADONE   = 10;
    localparam int C_IDONE   = 12;
    localparam int C_BUSY    = 30;

    // interrupt status / enable bit positions
    localparam int S_ERR   = 0;
    localparam int S_INV   = 1;
    localparam int S_DESC  = 2;
    localparam int S_ABORT = 3;
    localparam int E_PDONE = 4;
    localparam int E_IDONE = 5;

    localparam int NUM_STAT  = 4;
    localparam int NUM_FLAGS = 4;  // {imm, abort, pause, invalid}

    typedef struct packed {
        logic start;
        logic pause;
        logic abort;
    } cmd_t;

    typedef struct packed {
        logic       wb_en;
        logic       ring_stop;
        logic [1:0] mode;
    } cfg_t;

    typedef struct packed {
        logic imm;
        logic abrt;
        logic pause;
    } done_t;

    function automatic cmd_t decode_cmd(input logic [31:0] w);
        cmd_t c;
        c.start = w[C_START];
        c.pause = w[C_PAUSE];
        c.abort = w[C_ABORT];
        return c;
    endfunction

    function automatic cfg_t decode_cfg(input logic [31:0] w);
        cfg_t c;
        c.wb_en     = w[C_WB];
        c.ring_stop = w[C_RSTOP];
        c.mode      = w[C_MODE_LO +: 2];
        return c;
    endfunction

    // flag vector order: [0]=invalid [1]=pause done [2]=abort done [3]=imm done
    function automatic logic [NUM_FLAGS-1:0] flag_clear_mask(input logic [31:0] w);
        return {w[C_IDONE], w[C_ADONE], w[C_PDONE], w[C_INV]};
    endfunction

endpackage

// File: rtl/dmactl_sticky.sv
module dmactl_sticky #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    // per-bit sticky cell: a set in the same cycle as a clear wins
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic b_q;
        always_ff @(posedge clk) begin
            if (rst)           b_q <= 1'b0;
            else if (set_i[i]) b_q <= 1'b1;
            else if (clr_i[i]) b_q <= 1'b0;
        end
        assign q_o[i] = b_q;
    end
endmodule

// File: rtl/dmactl_fsm.sv
module dmactl_fsm
    import dmactl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cmd_valid,
    input  cmd_t      cmd,
    input  logic      eng_idle,
    input  logic      inv_evt,
    input  logic      ring_stop,
    output ch_state_e state_o,
    output done_t     done_o
);
    ch_state_e state_q, state_d;
    done_t     done_d;

    always_comb begin
        state_d = state_q;
        done_d  = '0;
        unique case (state_q)
            CH_IDLE: begin
                if (cmd_valid) begin
                    if (cmd.abort)      done_d.abrt  = 1'b1;
                    else if (cmd.pause) done_d.pause = 1'b1;
                    else if (cmd.start) state_d      = CH_RUN;
                end
            end
            CH_RUN: begin
                if (cmd_valid && cmd.abort)      state_d = CH_ABORTING;
                else if (cmd_valid && cmd.pause) state_d = CH_PAUSING;
                else if (inv_evt && ring_stop) begin
                    state_d    = CH_IDLE;
                    done_d.imm = 1'b1;
                end
            end
            CH_PAUSING: begin
                if (cmd_valid && cmd.abort) state_d = CH_ABORTING;
                else if (eng_idle) begin
                    state_d      = CH_IDLE;
                    done_d.pause = 1'b1;
                end
            end
            CH_ABORTING: begin
                if (eng_idle) begin
                    state_d     = CH_IDLE;
                    done_d.abrt = 1'b1;
                end
            end
            default: state_d = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= CH_IDLE;
        else     state_q <= state_d;
    end

    assign state_o = state_q;
    assign done_o  = done_d;
endmodule

// File: rtl/dmactl_irq.sv
module dmactl_irq
    import dmactl_pkg::*;
#(
    parameter int IST_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ist_wr,
    input  logic                ien_wr,
    input  logic [IST_W-1:0]    wdata,
    input  logic [NUM_STAT-1:0] ev,
    input  logic                pdone_flag,
    input  logic                idone_flag,
    output logic [IST_W-1:0]    ist_o,
    output logic [IST_W-1:0]    ien_o,
    output logic                irq_o
);
    localparam logic [IST_W-1:0] IEN_MASK =
        IST_W'((1 << S_ERR) | (1 << S_INV) | (1 << S_ABORT) | (1 << E_PDONE) | (1 << E_IDONE));

    logic [NUM_STAT-1:0] stat_q;
    logic [NUM_STAT-1:0] stat_clr;
    logic [IST_W-1:0]    ien_q;

    assign stat_clr = ist_wr ? wdata[NUM_STAT-1:0] : '0;

    dmactl_sticky #(.W(NUM_STAT)) u_stat (
        .clk   (clk),
        .rst   (rst),
        .set_i (ev),
        .clr_i (stat_clr),
        .q_o   (stat_q)
    );

    always_ff @(posedge clk) begin
        if (rst)         ien_q <= '0;
        else if (ien_wr) ien_q <= wdata & IEN_MASK;
    end

    assign ist_o = {{(IST_W-NUM_STAT){1'b0}}, stat_q};
    assign ien_o = ien_q;

    assign irq_o = (stat_q[S_ERR]   & ien_q[S_ERR])
                 | (stat_q[S_INV]   & ien_q[S_INV])
                 | (stat_q[S_ABORT] & ien_q[S_ABORT])
                 |  stat_q[S_DESC]
                 | (pdone_flag      & ien_q[E_PDONE])
                 | (idone_flag      & ien_q[E_IDONE]);
endmodule

// File: rtl/dmactl_top.sv
module dmactl_top
    import dmactl_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2,
    parameter int IST_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              eng_run,
    output logic              eng_pause_req,
    output logic              eng_abort_req,
    input  logic              eng_idle,
    output logic              cfg_wb_en,
    output logic              cfg_ring_stop,
    output logic [1:0]        cfg_mode,
    input  logic              evt_desc_done,
    input  logic              evt_invalid,
    input  logic              evt_error,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_IST  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(2);

    logic ctrl_wr, ist_wr, ien_wr;
    assign ctrl_wr = reg_wr_en && (reg_addr == A_CTRL);
    assign ist_wr  = reg_wr_en && (reg_addr == A_IST);
    assign ien_wr  = reg_wr_en && (reg_addr == A_IEN);

    logic [31:0] wword;
    assign wword = 32'(reg_wdata);

    cmd_t      cmd;
    ch_state_e state;
    done_t     done;
    cfg_t      cfg_q;

    assign cmd = decode_cmd(wword);

    dmactl_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (ctrl_wr),
        .cmd       (cmd),
        .eng_idle  (eng_idle),
        .inv_evt   (evt_invalid),
        .ring_stop (cfg_q.ring_stop),
        .state_o   (state),
        .done_o    (done)
    );

    // configuration is only accepted while the channel is idle
    always_ff @(posedge clk) begin
        if (rst)                               cfg_q <= '0;
        else if (ctrl_wr && state == CH_IDLE)  cfg_q <= decode_cfg(wword);
    end

    // control-word completion flags: [0]=invalid [1]=pause [2]=abort [3]=imm
    logic [NUM_FLAGS-1:0] flag_set, flag_clr, flag_q;
    assign flag_set = {done.imm, done.abrt, done.pause, evt_invalid};
    assign flag_clr = ctrl_wr ? flag_clear_mask(wword) : '0;

    dmactl_sticky #(.W(NUM_FLAGS)) u_flags (
        .clk   (clk),
        .rst   (rst),
        .set_i (flag_set),
        .clr_i (flag_clr),
        .q_o   (flag_q)
    );

    logic [IST_W-1:0]    ist, ien;
    logic [NUM_STAT-1:0] stat_ev;
    always_comb begin
        stat_ev          = '0;
        stat_ev[S_ERR]   = evt_error;
        stat_ev[S_INV]   = evt_invalid;
        stat_ev[S_DESC]  = evt_desc_done;
        stat_ev[S_ABORT] = done.abrt;
    end

    dmactl_irq #(.IST_W(IST_W)) u_irq (
        .clk        (clk),
        .rst        (rst),
        .ist_wr     (ist_wr),
        .ien_wr     (ien_wr),
        .wdata      (reg_wdata[IST_W-1:0]),
        .ev         (stat_ev),
        .pdone_flag (flag_q[1]),
        .idone_flag (flag_q[3]),
        .ist_o      (ist),
        .ien_o      (ien),
        .irq_o      (irq)
    );

    logic [31:0] ctrl_word;
    always_comb begin
        ctrl_word                   = '0;
        ctrl_word[C_PAUSE]          = (state == CH_PAUSING);
        ctrl_word[C_ABORT]          = (state == CH_ABORTING);
        ctrl_word[C_WB]             = cfg_q.wb_en;
        ctrl_word[C_RSTOP]          = cfg_q.ring_stop;
        ctrl_word[C_MODE_LO +: 2]   = cfg_q.mode;
        ctrl_word[C_INV]            = flag_q[0];
        ctrl_word[C_PDONE]          = flag_q[1];
        ctrl_word[C_ADONE]          = flag_q[2];
        ctrl_word[C_IDONE]          = flag_q[3];
        ctrl_word[C_BUSY]           = (state != CH_IDLE);
    end

    always_comb begin
        unique case (reg_addr)
            A_CTRL:  reg_rdata = DATA_W'(ctrl_word);
            A_IST:   reg_rdata = DATA_W'(ist);
            A_IEN:   reg_rdata = DATA_W'(ien);
            default: reg_rdata = '0;
        endcase
    end

    assign eng_run       = (state != CH_IDLE);
    assign eng_pause_req = (state == CH_PAUSING);
    assign eng_abort_req = (state == CH_ABORTING);
    assign cfg_wb_en     = cfg_q.wb_en;
    assign cfg_ring_stop = cfg_q.ring_stop;
    assign cfg_mode      = cfg_q.mode;
endmodule

// File: rtl/dmactl_chk.sv
module dmactl_chk (
    input logic       clk,
    input logic       rst,
    input logic       ctrl_wr,
    input logic [1:0] wcmd,       // {abort, start}
    input logic       eng_run,
    input logic       eng_pause_req,
    input logic       eng_abort_req,
    input logic       eng_idle,
    input logic       evt_error,
    input logic [3:0] flags,
    input logic [3:0] stat,
    input logic       irq
);
    p_pause_done_r3: assert property (@(posedge clk) disable iff (rst)
        (eng_pause_req && eng_idle && !(ctrl_wr && wcmd[1])) |=> (flags[1] && !eng_run));

    p_pause_holds_r3: assert property (@(posedge clk) disable iff (rst)
        (eng_pause_req && !eng_idle && !(ctrl_wr && wcmd[1])) |=> eng_pause_req);

    p_abort_done_r4: assert property (@(posedge clk) disable iff (rst)
        (eng_abort_req && eng_idle) |=> (flags[2] && stat[3] && !eng_run));

    p_req_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({eng_pause_req, eng_abort_req}));

    p_event_wins_r7: assert property (@(posedge clk) disable iff (rst)
        evt_error |=> stat[0]);

    p_desc_irq_r10: assert property (@(posedge clk) disable iff (rst)
        stat[2] |-> irq);

    p_start_r2: assert property (@(posedge clk) disable iff (rst)
        (!eng_run && ctrl_wr && wcmd[0] && !wcmd[1]) |=> eng_run);
endmodule

bind dmactl_top dmactl_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .ctrl_wr       (ctrl_wr),
    .wcmd          ({cmd.abort | cmd.pause, cmd.start & ~cmd.pause}),
    .eng_run       (eng_run),
    .eng_pause_req (eng_pause_req),
    .eng_abort_req (eng_abort_req),
    .eng_idle      (eng_idle),
    .evt_error     (evt_error),
    .flags         (flag_q),
    .stat          (ist[3:0]),
    .irq           (irq)
);

// File: tb/dmactl_top_tb.sv
module dmactl_top_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        eng_run, eng_pause_req, eng_abort_req;
    logic        eng_idle = 1'b0;
    logic        cfg_wb_en, cfg_ring_stop;
    logic [1:0]  cfg_mode;
    logic        evt_desc_done = 1'b0, evt_invalid = 1'b0, evt_error = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done_run = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmactl_top u_dut (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_run(eng_run),
        .eng_pause_req(eng_pause_req), .eng_abort_req(eng_abort_req),
        .eng_idle(eng_idle), .cfg_wb_en(cfg_wb_en), .cfg_ring_stop(cfg_ring_stop),
        .cfg_mode(cfg_mode), .evt_desc_done(evt_desc_done), .evt_invalid(evt_invalid),
        .evt_error(evt_error), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic rd(input string req, input logic [1:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: evt_error     = 1'b1;
            1: evt_invalid   = 1'b1;
            2: evt_desc_done = 1'b1;
            default: eng_idle = 1'b1;
        endcase
        @(negedge clk);
        evt_error = 1'b0; evt_invalid = 1'b0; evt_desc_done = 1'b0; eng_idle = 1'b0;
    endtask

    task automatic t_reset;
        rd("R1", 2'd0, 32'h0);
        rd("R1", 2'd1, 32'h0);
        rd("R1", 2'd2, 32'h0);
        check("R1", {eng_run, eng_pause_req, eng_abort_req, irq}, 4'b0000);
    endtask

    task automatic t_start;
        wr(2'd0, 32'h0000_174C);
        rd("R2", 2'd0, 32'h4000_0044);
        check("R2", {eng_run, cfg_wb_en, cfg_ring_stop, cfg_mode}, 5'b11010);
        // R12: start + new config while running is ignored
        wr(2'd0, 32'h0000_0038);
        rd("R12", 2'd0, 32'h4000_0044);
    endtask

    task automatic t_pause;
        wr(2'd0, 32'h0000_0001);
        rd("R3", 2'd0, 32'h4000_0045);
        repeat (3) @(negedge clk);
        check("R3", {eng_pause_req, eng_run}, 2'b11);
        pulse(3);
        rd("R3", 2'd0, 32'h0000_0244);
        check("R3", {eng_pause_req, eng_run}, 2'b00);
    endtask

    task automatic t_w1c;
        wr(2'd0, 32'h0000_0000);
        rd("R6", 2'd0, 32'h0000_0200);
        wr(2'd0, 32'h0000_0200);
        rd("R6", 2'd0, 32'h0000_0000);
    endtask

    task automatic t_idle_pause;
        wr(2'd0, 32'h0000_1701);
        rd("R5", 2'd0, 32'h0000_0200);
        check("R5", {eng_run}, 1'b0);
    endtask

    task automatic t_abort;
        wr(2'd0, 32'h0000_1700);
        wr(2'd0, 32'h0000_0008);
        rd("R2", 2'd0, 32'h4000_0000);
        wr(2'd0, 32'h0000_0001);
        wr(2'd0, 32'h0000_0002);
        check("R4", {eng_pause_req, eng_abort_req}, 2'b01);
        rd("R4", 2'd0, 32'h4000_0002);
        pulse(3);
        rd("R4", 2'd0, 32'h0000_0400);
        rd("R4", 2'd1, 32'h0000_0008);
        check("R4", {eng_run}, 1'b0);
    endtask

    task automatic t_status;
        pulse(0); pulse(1); pulse(2);
        rd("R8", 2'd1, 32'h0000_000F);
        rd("R11", 2'd0, 32'h0000_0500);
        check("R10", {31'b0, irq}, 32'h1);
        wr(2'd1, 32'h0000_0005);
        rd("R8", 2'd1, 32'h0000_000A);
        check("R10", {31'b0, irq}, 32'h0);
        wr(2'd2, 32'h0000_FFFF);
        rd("R9", 2'd2, 32'h0000_003B);
        check("R10", {31'b0, irq}, 32'h1);
    endtask

    task automatic t_collide;
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h1; evt_error = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_wdata = '0; evt_error = 1'b0;
        rd("R7", 2'd1, 32'h0000_000B);
    endtask

    task automatic t_ring_stop;
        wr(2'd2, 32'h0); wr(2'd1, 32'hF); wr(2'd0, 32'h0000_1700);
        rd("R8", 2'd1, 32'h0);
        check("R10", {31'b0, irq}, 32'h0);
        wr(2'd0, 32'h0000_0018);
        rd("R11", 2'd0, 32'h4000_0010);
        pulse(1);
        rd("R11", 2'd0, 32'h0000_1110);
        check("R11", {eng_run}, 1'b0);
        wr(2'd2, 32'h0000_0020);
        check("R10", {31'b0, irq}, 32'h1);
        wr(2'd2, 32'h0); wr(2'd1, 32'hF); wr(2'd0, 32'h0000_1700);
        wr(2'd0, 32'h0000_0008);
        pulse(1);
        rd("R11", 2'd0, 32'h4000_0100);
        check("R11", {eng_run}, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_start();
        t_pause();
        t_w1c();
        t_idle_pause();
        t_abort();
        t_status();
        t_collide();
        t_ring_stop();
        done_run = 1'b1;
    end

    initial begin
        fork
            begin wait (done_run); end
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule